// File: doc/BRIEF.md
# Sixteen-Line Interrupt Aggregator

This block gathers sixteen external interrupt request lines into one active-high, level-sensitive interrupt for a host processor. Each line first passes through a two-flop synchronizer. While its synchronized level is high, the line sets a sticky pending bit. The host enables lines one bit at a time through a mask register. The host interrupt is asserted whenever at least one line is both pending and enabled.

The host reaches the block over a plain 16-bit memory-mapped port with a byte address, write data, a write strobe, a read strobe and read data.

- Pending bits are acknowledged by writing ones to the status address.
- The mask has two addresses. Writing ones to one address enables lines. Writing ones to the other address disables them.
- A separate read-only address returns the live synchronized levels of the lines.

The port has no back-pressure. Every strobe is taken in the cycle it is presented. Read data comes from a register, so it appears after the clock edge that samples the read strobe. It then holds until the next read.

Top module: `irqx_aggregator`

## Requirements
- R1: After reset, every pending bit and every enable bit is 0, `host_irq` is low and `bus_rdata` is 0.
- R2: A line whose input is high at a clock edge shows as pending after the third rising edge (two synchronizer flops, then the pending flop). The pending bit stays 1 after the input falls, until it is acknowledged.
- R3: A write to address 0x16 clears each pending bit whose write-data bit is 1. Pending bits under a 0 write-data bit are unchanged. A read of 0x16 returns the pending bits, with bit i for line i.
- R4: If a line's synchronized level is high in the same cycle that its pending bit is acknowledged, the set wins and the bit stays 1.
- R5: A read of 0x18 returns the synchronized, unlatched level of each line (bit i for line i). It does not reflect pending bits that have been latched.
- R6: A write to 0x1A sets each enable bit whose write-data bit is 1 and leaves the others. A read of 0x1A returns the enable mask, where 1 means enabled.
- R7: A write to 0x1C clears each enable bit whose write-data bit is 1 and leaves the others. A read of 0x1C also returns the enable mask.
- R8: `host_irq` is high exactly while some line has both its pending bit and its enable bit at 1. It is low whenever the mask is all zero.
- R9: A read of any address other than 0x16, 0x18, 0x1A and 0x1C returns 0. A write to any such address, or to the read-only address 0x18, changes no pending bit and no enable bit.
- R10: With all inputs low, writing 0xFFFF to 0x1C and then 0xFFFF to 0x16 leaves every line disabled and every pending bit cleared.
- R11: `bus_rdata` changes only at the edge that samples `bus_rd` high. At that edge it takes the register value from just before the edge, and it holds in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_in | input | 16 | Asynchronous interrupt request lines, active high |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_rd | input | 1 | Read strobe, one access per high cycle |
| bus_rdata | output | 16 | Registered read data |
| host_irq | output | 1 | Aggregated interrupt to the host, active-high level |

## Verification
The assertions check the following on every cycle:
- Mask set and clear writes take effect, and other traffic leaves the mask unchanged.
- Pending bits never drop unless they are acknowledged.
- A synchronized high level always lands in its pending bit, even against an acknowledge.
- Unmapped reads return zero, and read data holds between reads.
- The host interrupt stays low while the mask is all zero.

The bench's scenarios are needed to show the end-to-end latency of the synchronizer, the difference between live and latched status, the start-up clearing sequence, and the exact interrupt level under mixed random traffic. The bench checks these against its own cycle model of the registers.

// File: rtl/irqx_pkg.sv
package irqx_pkg;

  // Register byte offsets. The host software decodes these, so they are fixed.
  localparam logic [7:0] OFS_PEND = 8'h16;
  localparam logic [7:0] OFS_LIVE = 8'h18;
  localparam logic [7:0] OFS_MSET = 8'h1A;
  localparam logic [7:0] OFS_MCLR = 8'h1C;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_PEND = 3'd1,
    SEL_LIVE = 3'd2,
    SEL_MSET = 3'd3,
    SEL_MCLR = 3'd4
  } regsel_e;

endpackage

// File: rtl/irqx_sync.sv
module irqx_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  localparam int LAST = STAGES - 1;

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign sync_out = stg[LAST];
endmodule

// File: rtl/irqx_decode.sv
module irqx_decode
  import irqx_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output regsel_e           sel
);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
  localparam logic [ADDR_W-1:0] A_LIVE = ADDR_W'(OFS_LIVE);
  localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(OFS_MSET);
  localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(OFS_MCLR);

  always_comb begin
    unique case (addr)
      A_PEND:  sel = SEL_PEND;
      A_LIVE:  sel = SEL_LIVE;
      A_MSET:  sel = SEL_MSET;
      A_MCLR:  sel = SEL_MCLR;
      default: sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/irqx_pending.sv
module irqx_pending #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] ack,
  output logic [W-1:0] pend
);
  // Per-line sticky bit: a high level sets it, an ack clears it, and set beats clear.
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)        pend[i] <= 1'b0;
      else if (level[i]) pend[i] <= 1'b1;
      else if (ack[i])   pend[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irqx_mask.sv
module irqx_mask #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_bits,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] enable
);
  always_ff @(posedge clk) begin
    if (!rst_n) enable <= '0;
    else        enable <= (enable | set_bits) & ~clr_bits;
  end
endmodule

// File: rtl/irqx_aggregator.sv
module irqx_aggregator
  import irqx_pkg::*;
#(
  parameter int N_LINES     = 16,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [N_LINES-1:0] bus_wdata,
  input  logic               bus_wr,
  input  logic               bus_rd,
  output logic [N_LINES-1:0] bus_rdata,
  output logic               host_irq
);
  localparam logic [N_LINES-1:0] ZERO = '0;

  regsel_e            sel;
  logic [N_LINES-1:0] sync_lvl;
  logic [N_LINES-1:0] status_q;
  logic [N_LINES-1:0] mask_q;
  logic [N_LINES-1:0] ack_v, mset_v, mclr_v;
  logic [N_LINES-1:0] rd_mux;

  irqx_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  irqx_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (irq_in),
    .sync_out (sync_lvl)
  );

  assign ack_v  = (bus_wr && sel == SEL_PEND) ? bus_wdata : ZERO;
  assign mset_v = (bus_wr && sel == SEL_MSET) ? bus_wdata : ZERO;
  assign mclr_v = (bus_wr && sel == SEL_MCLR) ? bus_wdata : ZERO;

  irqx_pending #(.W(N_LINES)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .level (sync_lvl),
    .ack   (ack_v),
    .pend  (status_q)
  );

  irqx_mask #(.W(N_LINES)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_bits (mset_v),
    .clr_bits (mclr_v),
    .enable   (mask_q)
  );

  always_comb begin
    unique case (sel)
      SEL_PEND:          rd_mux = status_q;
      SEL_LIVE:          rd_mux = sync_lvl;
      SEL_MSET, SEL_MCLR: rd_mux = mask_q;
      default:           rd_mux = ZERO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= ZERO;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign host_irq = |(status_q & mask_q);
endmodule

// File: rtl/irqx_checker.sv
module irqx_checker
  import irqx_pkg::*;
#(
  parameter int N_LINES = 16,
  parameter int ADDR_W  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [N_LINES-1:0] bus_wdata,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [N_LINES-1:0] bus_rdata,
  input logic               host_irq,
  input logic [N_LINES-1:0] status_q,
  input logic [N_LINES-1:0] mask_q,
  input logic [N_LINES-1:0] sync_lvl
);
  logic is_pend, is_live, is_mset, is_mclr, mapped;
  logic [N_LINES-1:0] ack_seen;

  assign is_pend  = bus_addr == ADDR_W'(OFS_PEND);
  assign is_live  = bus_addr == ADDR_W'(OFS_LIVE);
  assign is_mset  = bus_addr == ADDR_W'(OFS_MSET);
  assign is_mclr  = bus_addr == ADDR_W'(OFS_MCLR);
  assign mapped   = is_pend | is_live | is_mset | is_mclr;
  assign ack_seen = (bus_wr && is_pend) ? bus_wdata : '0;

  p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && is_mset) |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));

  p_mask_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && is_mclr) |=> ((mask_q & $past(bus_wdata)) == '0));

  p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (is_mset || is_mclr)) |=> $stable(mask_q));

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (($past(status_q) & ~$past(ack_seen) & ~status_q) == '0));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_lvl != '0) |=> ((status_q & $past(sync_lvl)) == $past(sync_lvl)));

  p_unmapped_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !mapped) |=> (bus_rdata == '0));

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !host_irq);
endmodule

bind irqx_aggregator irqx_checker #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .host_irq  (host_irq),
  .status_q  (status_q),
  .mask_q    (mask_q),
  .sync_lvl  (sync_lvl)
);

// File: tb/tb_irqx_aggregator.sv
module tb_irqx_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_rdata;
  logic        host_irq;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit mon_on = 0;

  always #2 clk = ~clk;

  irqx_aggregator dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .host_irq(host_irq)
  );

  // Cycle model built from the requirements.
  logic [15:0] m_s1 = '0, m_s2 = '0, m_pend = '0, m_mask = '0, m_rd = '0;

  function automatic logic [15:0] rd_value(logic [7:0] a, logic [15:0] p,
                                           logic [15:0] lv, logic [15:0] m);
    case (a)
      8'h16:        return p;
      8'h18:        return lv;
      8'h1A, 8'h1C: return m;
      default:      return 16'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_pend <= '0; m_mask <= '0; m_rd <= '0;
    end else begin
      m_s1 <= irq_in;
      m_s2 <= m_s1;
      m_pend <= (m_pend & ~((bus_wr && bus_addr == 8'h16) ? bus_wdata : 16'h0)) | m_s2;
      if (bus_wr && bus_addr == 8'h1A) m_mask <= m_mask | bus_wdata;
      if (bus_wr && bus_addr == 8'h1C) m_mask <= m_mask & ~bus_wdata;
      if (bus_rd) m_rd <= rd_value(bus_addr, m_pend, m_s2, m_mask);
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Continuous comparison away from the active edge (R8, R11).
  always @(negedge clk) begin
    if (mon_on) begin
      chk("R8 host_irq", {15'h0, host_irq}, {15'h0, |(m_pend & m_mask)});
      chk("R11 rdata", bus_rdata, m_rd);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1234));
    idle(3);
    chk("R1 irq at reset", {15'h0, host_irq}, 16'h0);
    chk("R1 rdata at reset", bus_rdata, 16'h0);
    @(negedge clk); rst_n = 1'b1; mon_on = 1;
    rd(8'h16, v); chk("R1 pend", v, 16'h0);
    rd(8'h1A, v); chk("R1 mask", v, 16'h0);

    // R10 start-up clearing sequence
    wr(8'h1A, 16'h00FF);
    wr(8'h1C, 16'hFFFF);
    wr(8'h16, 16'hFFFF);
    rd(8'h1C, v); chk("R10 mask cleared", v, 16'h0);
    rd(8'h16, v); chk("R10 pend cleared", v, 16'h0);

    // R2 single pulse latches, R5 live level has fallen
    @(negedge clk); irq_in = 16'h0008;
    @(negedge clk); irq_in = 16'h0000;
    idle(4);
    rd(8'h16, v); chk("R2 pulse latched", v, 16'h0008);
    rd(8'h18, v); chk("R5 live after pulse", v, 16'h0000);
    chk("R8 masked no irq", {15'h0, host_irq}, 16'h0);

    // R6 enable line 3
    wr(8'h1A, 16'h0008);
    rd(8'h1A, v); chk("R6 mask set", v, 16'h0008);
    chk("R8 irq raised", {15'h0, host_irq}, 16'h1);

    // R3 zero bits leave pending, one bits clear
    wr(8'h16, 16'h0001);
    rd(8'h16, v); chk("R3 other bit ack", v, 16'h0008);
    wr(8'h16, 16'h0008);
    rd(8'h16, v); chk("R3 ack clears", v, 16'h0000);
    chk("R8 irq dropped", {15'h0, host_irq}, 16'h0);

    // R4 set wins while held high; R5 live level
    @(negedge clk); irq_in = 16'h0020;
    idle(4);
    rd(8'h18, v); chk("R5 live high", v, 16'h0020);
    wr(8'h16, 16'h0020);
    rd(8'h16, v); chk("R4 set wins", v, 16'h0020);
    @(negedge clk); irq_in = 16'h0000;
    idle(4);
    wr(8'h16, 16'h0020);
    rd(8'h16, v); chk("R3 ack after drop", v, 16'h0000);

    // R7 partial clear, both mask addresses read the mask
    wr(8'h1A, 16'hFFFF);
    wr(8'h1C, 16'h00F0);
    rd(8'h1C, v); chk("R7 mask clear", v, 16'hFF0F);
    rd(8'h1A, v); chk("R7 mask via set addr", v, 16'hFF0F);

    // R9 unmapped and read-only writes ignored, unmapped reads zero
    @(negedge clk); irq_in = 16'h0100;
    @(negedge clk); irq_in = 16'h0000;
    idle(4);
    wr(8'h20, 16'hFFFF);
    wr(8'h18, 16'hFFFF);
    wr(8'h17, 16'hFFFF);
    rd(8'h1A, v); chk("R9 mask untouched", v, 16'hFF0F);
    rd(8'h16, v); chk("R9 pend untouched", v, 16'h0100);
    rd(8'h00, v); chk("R9 unmapped read", v, 16'h0000);
    rd(8'h17, v); chk("R9 odd addr read", v, 16'h0000);

    // Random traffic checked by the continuous model comparison (R8, R11)
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (($urandom % 4) == 0) irq_in = 16'(1 << ($urandom % 16));
      else if (($urandom % 3) == 0) irq_in = 16'h0;
      case ($urandom % 6)
        0: bus_addr = 8'h16;
        1: bus_addr = 8'h18;
        2: bus_addr = 8'h1A;
        3: bus_addr = 8'h1C;
        default: bus_addr = 8'($urandom);
      endcase
      bus_wdata = 16'($urandom);
      bus_wr = (($urandom % 3) == 0);
      bus_rd = !bus_wr && (($urandom % 2) == 0);
    end
    @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0; irq_in = '0;
    idle(4);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule